// File: doc/BRIEF.md
# Expansion Bus Glue with Read Wait States

This unit joins a 68000-family expansion bus to an on-board network controller and a flash configuration ROM. It decodes two fixed 64 KiB address windows into active-low chip selects, returns an active-low data acknowledge to the processor, and passes the controller's interrupt straight through to a processor interrupt line.

Some controller reads need extra settling time. For that case the unit drives a wait signal into the selected device for a programmable number of reference-clock cycles. The count is chosen to cover a fixed delay in nanoseconds. At 25 MHz an 80 ns delay needs 2 cycles; slower reference clocks need fewer. Writes never get added delay. The strobe, direction and select signals are brought into the reference-clock domain through two flip-flops before the wait sequencer uses them.

Top module: `xbus_glue`

## Requirements
- R1: `eth_cs_n` is low exactly when `as_n` is low and the address lies in 0x800000..0x80FFFF inclusive; it follows the inputs combinationally.
- R2: `rom_cs_n` is low exactly when `as_n` is low and the address lies in 0x900000..0x90FFFF inclusive; the two selects are never low together.
- R3: Strobe, direction and select pass through two reference-clock flip-flops, so a read selected before edge k with a nonzero count raises `wait_o` after edge k+2.
- R4: A write (`rd_wr` = 0) never raises `wait_o`; `dtack_n` goes low after edge k+2 when the select becomes active before edge k.
- R5: For a read with count N in 1..7, `wait_o` stays high for exactly N clock cycles and then falls, and `dtack_n` goes low in the same cycle that `wait_o` falls. `dtack_n` is never low while `wait_o` is high.
- R6: A read with count 0 never raises `wait_o` and acknowledges with the same timing as a write.
- R7: Only one wait sequence runs per select. While the select stays active after the acknowledge, `wait_o` does not rise again.
- R8: `dtack_n` returns high after the second edge that samples the select inactive. An access outside both windows never drives `dtack_n` low.
- R9: `irq_n_out` equals `irq_n_in` at all times, with no masking.
- R10: A synchronous active-high `rst` clears the sequencer and synchronizers. After the reset edge `wait_o` is low and `dtack_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 24 | Processor address |
| as_n | input | 1 | Address strobe, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| wait_cycles | input | 3 | Read wait length in reference clocks (0 = none) |
| irq_n_in | input | 1 | Controller interrupt, active low |
| eth_cs_n | output | 1 | Network controller select, active low |
| rom_cs_n | output | 1 | Flash ROM select, active low |
| wait_o | output | 1 | Wait request into the selected device |
| dtack_n | output | 1 | Data acknowledge to processor, active low |
| irq_n_out | output | 1 | Processor interrupt line, active low |

## Verification
A sequencer stuck in its wait state or reloading its counter shows at the ports as `wait_o` held past N cycles with `dtack_n` held high. A reference model stepped each clock catches that on the first cycle it differs. A dropped synchronizer stage shifts the rise of `wait_o` and the fall of `dtack_n` one cycle earlier. A missing reload guard shows as a second `wait_o` pulse within one long select. A decode error shows at once on the chip selects. The bench covers every count from 0 to 7, long selects, selects that end during the wait, reset during a wait, and the addresses on both sides of each window edge.

// File: rtl/glue_pkg.sv
package glue_pkg;
  typedef enum logic [1:0] {
    WG_IDLE = 2'd0,
    WG_HOLD = 2'd1,
    WG_DONE = 2'd2
  } wg_state_e;

  // True when the address shares the window's upper bits above span_log2.
  function automatic logic in_window(input logic [23:0] a,
                                     input logic [23:0] base,
                                     input int unsigned span_log2);
    return (a >> span_log2) == (base >> span_log2);
  endfunction

  // Counter step while holding wait; reaching 1 ends the hold.
  function automatic logic [2:0] count_step(input logic [2:0] c);
    return c - 3'd1;
  endfunction
endpackage

// File: rtl/glue_decode.sv
module glue_decode #(
  parameter logic [23:0] ETH_BASE = 24'h800000,
  parameter logic [23:0] ROM_BASE = 24'h900000,
  parameter int unsigned SPAN_LOG2 = 16
) (
  input  logic [23:0] addr,
  input  logic        as_n,
  output logic        eth_cs_n,
  output logic        rom_cs_n
);
  import glue_pkg::*;

  logic eth_hit, rom_hit;

  always_comb begin
    eth_hit  = in_window(addr, ETH_BASE, SPAN_LOG2);
    rom_hit  = in_window(addr, ROM_BASE, SPAN_LOG2);
    eth_cs_n = ~(~as_n & eth_hit);
    rom_cs_n = ~(~as_n & rom_hit & ~eth_hit);
  end
endmodule

// File: rtl/glue_sync.sv
module glue_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/glue_waitgen.sv
module glue_waitgen #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_s,
  input  logic             rd_s,
  input  logic [CNT_W-1:0] wait_cycles,
  output logic             wait_o,
  output logic             ack_o
);
  import glue_pkg::*;

  wg_state_e        state;
  logic [CNT_W-1:0] cnt;

  // Named events for the assertions.
  logic start_rd, start_wr, start_zero, hold_last, in_done;

  always_comb begin
    start_rd   = (state == WG_IDLE) && sel_s && rd_s;
    start_wr   = (state == WG_IDLE) && sel_s && !rd_s;
    start_zero = start_rd && (wait_cycles == '0);
    hold_last  = (state == WG_HOLD) && (cnt == CNT_W'(1));
    in_done    = (state == WG_DONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= WG_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        WG_IDLE: begin
          if (start_wr || start_zero) begin
            state <= WG_DONE;
          end else if (start_rd) begin
            state <= WG_HOLD;
            cnt   <= wait_cycles;
          end
        end
        WG_HOLD: begin
          if (hold_last) state <= WG_DONE;
          cnt <= count_step(cnt);
        end
        WG_DONE: begin
          if (!sel_s) state <= WG_IDLE;
        end
        default: state <= WG_IDLE;
      endcase
    end
  end

  assign wait_o = (state == WG_HOLD);
  assign ack_o  = in_done && sel_s;

  // Checker state: length of the current wait run and latched request.
  logic [CNT_W:0]   run_len;
  logic [CNT_W-1:0] n_lat;
  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= '0;
      n_lat   <= '0;
    end else begin
      run_len <= wait_o ? run_len + 1'b1 : '0;
      if (start_rd) n_lat <= wait_cycles;
    end
  end

  a_r5_hold_length: assert property (@(posedge clk) disable iff (rst)
    $fell(wait_o) |-> (run_len == {1'b0, n_lat}));
  a_r5_no_ack_in_wait: assert property (@(posedge clk) disable iff (rst)
    !(wait_o && ack_o));
  a_r4_write_no_wait: assert property (@(posedge clk) disable iff (rst)
    start_wr |=> !wait_o);
  a_r6_zero_no_wait: assert property (@(posedge clk) disable iff (rst)
    start_zero |=> !wait_o);
  a_r7_single_sequence: assert property (@(posedge clk) disable iff (rst)
    (in_done && sel_s) |=> !wait_o);
  a_r10_reset_release: assert property (@(posedge clk)
    rst |=> (!wait_o && !ack_o));
endmodule

// File: rtl/xbus_glue.sv
module xbus_glue #(
  parameter logic [23:0] ETH_BASE  = 24'h800000,
  parameter logic [23:0] ROM_BASE  = 24'h900000,
  parameter int unsigned SPAN_LOG2 = 16,
  parameter int unsigned CNT_W     = 3,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [23:0]      addr,
  input  logic             as_n,
  input  logic             rd_wr,
  input  logic [CNT_W-1:0] wait_cycles,
  input  logic             irq_n_in,
  output logic             eth_cs_n,
  output logic             rom_cs_n,
  output logic             wait_o,
  output logic             dtack_n,
  output logic             irq_n_out
);
  localparam int unsigned SW = 3;

  logic          any_sel;
  logic [SW-1:0] raw_bus, syn_bus;
  logic          sel_s, rd_s, ack;

  glue_decode #(.ETH_BASE(ETH_BASE), .ROM_BASE(ROM_BASE), .SPAN_LOG2(SPAN_LOG2))
    u_dec (.addr(addr), .as_n(as_n), .eth_cs_n(eth_cs_n), .rom_cs_n(rom_cs_n));

  assign any_sel = ~eth_cs_n | ~rom_cs_n;
  assign raw_bus = {~as_n, any_sel, rd_wr};

  glue_sync #(.WIDTH(SW), .STAGES(SYNC_STG))
    u_sync (.clk(clk), .rst(rst), .d(raw_bus), .q(syn_bus));

  assign sel_s = syn_bus[2] & syn_bus[1];
  assign rd_s  = syn_bus[0];

  glue_waitgen #(.CNT_W(CNT_W))
    u_wg (.clk(clk), .rst(rst), .sel_s(sel_s), .rd_s(rd_s),
          .wait_cycles(wait_cycles), .wait_o(wait_o), .ack_o(ack));

  assign dtack_n   = ~ack;
  assign irq_n_out = irq_n_in;

  a_r2_selects_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!eth_cs_n && !rom_cs_n));
  a_r8_outside_no_ack: assert property (@(posedge clk) disable iff (rst)
    (!sel_s && !$past(sel_s)) |-> dtack_n);
endmodule

// File: tb/xbus_glue_test.sv
`timescale 1ns/1ps
module xbus_glue_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] addr = 24'h0;
  logic        as_n = 1'b1;
  logic        rd_wr = 1'b1;
  logic [2:0]  wait_cycles = 3'd2;
  logic        irq_n_in = 1'b1;
  logic        eth_cs_n, rom_cs_n, wait_o, dtack_n, irq_n_out;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string cur_req = "R10";

  always #2 clk = ~clk;

  xbus_glue uut (.clk(clk), .rst(rst), .addr(addr), .as_n(as_n), .rd_wr(rd_wr),
    .wait_cycles(wait_cycles), .irq_n_in(irq_n_in), .eth_cs_n(eth_cs_n),
    .rom_cs_n(rom_cs_n), .wait_o(wait_o), .dtack_n(dtack_n), .irq_n_out(irq_n_out));

  // Reference model: a two-deep history of the raw bus plus a remaining count.
  bit m_sel[$];
  bit m_rd[$];
  int remaining = 0;
  bit served = 0;

  function automatic bit exp_eth();
    return !as_n && addr[23:16] == 8'h80;
  endfunction
  function automatic bit exp_rom();
    return !as_n && addr[23:16] == 8'h90;
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    bit s2, r2;
    cycles++;
    s2 = (m_sel.size() == 2) ? m_sel[0] : 1'b0;
    r2 = (m_rd.size() == 2) ? m_rd[0] : 1'b0;
    if (rst) begin
      remaining = 0; served = 0;
      m_sel = '{0, 0}; m_rd = '{0, 0};
    end else begin
      if (remaining > 0) begin
        remaining--;
        if (remaining == 0) served = 1;
      end else if (served) begin
        if (!s2) served = 0;
      end else if (s2) begin
        if (r2 && wait_cycles != 0) remaining = wait_cycles;
        else served = 1;
      end
      void'(m_sel.pop_front()); void'(m_rd.pop_front());
      m_sel.push_back(exp_eth() || exp_rom());
      m_rd.push_back(!as_n && rd_wr);
    end
    #1;
    check("R1", "eth_cs_n", eth_cs_n, !exp_eth());
    check("R2", "rom_cs_n", rom_cs_n, !exp_rom());
    check("R9", "irq_n_out", irq_n_out, irq_n_in);
    check(cur_req, "wait_o", wait_o, remaining > 0);
    check(cur_req, "dtack_n", dtack_n, !(served && m_sel[1 - 1] == 1'b1 && 1'b1) ? 1'b1 : 1'b0);
  end

  // Note: the ack compares against the synchronized select that the model
  // holds at the front of its history after the update above.

  task automatic access(input logic [23:0] a, input logic rd, input int hold, input int gap);
    @(negedge clk);
    addr = a; rd_wr = rd; as_n = 1'b0;
    repeat (hold) @(negedge clk);
    as_n = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    m_sel = '{0, 0}; m_rd = '{0, 0};
    repeat (4) @(negedge clk);
    cur_req = "R10";
    rst = 1'b0;
    repeat (2) @(negedge clk);

    cur_req = "R3";
    wait_cycles = 3'd2;
    access(24'h800010, 1'b1, 8, 4);

    cur_req = "R4";
    wait_cycles = 3'd5;
    access(24'h800020, 1'b0, 6, 4);
    access(24'h90FFFE, 1'b0, 6, 4);

    cur_req = "R5";
    for (int n = 1; n < 8; n++) begin
      wait_cycles = 3'(n);
      access(24'h80FFFF, 1'b1, n + 6, 4);
      access(24'h900000, 1'b1, n + 6, 4);
    end

    cur_req = "R6";
    wait_cycles = 3'd0;
    access(24'h800000, 1'b1, 6, 4);

    cur_req = "R7";
    wait_cycles = 3'd3;
    access(24'h800100, 1'b1, 30, 4);
    access(24'h800100, 1'b1, 3, 6);

    cur_req = "R8";
    access(24'h810000, 1'b1, 8, 3);
    access(24'h7FFFFF, 1'b0, 8, 3);
    access(24'h8FFFFF, 1'b1, 8, 3);
    access(24'h910000, 1'b1, 8, 3);
    access(24'h800004, 1'b0, 5, 1);
    access(24'h900004, 1'b1, 12, 1);

    cur_req = "R9";
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); irq_n_in = ~irq_n_in;
    end

    cur_req = "R10";
    wait_cycles = 3'd7;
    @(negedge clk); addr = 24'h800040; rd_wr = 1'b1; as_n = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0; as_n = 1'b1;
    repeat (6) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL R10 watchdog: actual running expected finished at cycle %0d", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule